// File: doc/BRIEF.md
# Integer Execute Unit

This unit executes the integer operations of a 32-bit core. It accepts a 32-bit instruction word and the two source register values, and returns a 32-bit result, a 5-bit destination index and a write strobe. It handles both instruction formats. In the immediate format, the opcode sits in bits [5:0], a 16-bit immediate in [21:6], register B in [26:22] and register A in [31:27]. In the register format, the opcode is 58, with register C in [21:17], the extended opcode in [16:11] and a 5-bit shift amount in [10:6].

Every operation except divide writes its result one clock after issue. Divide runs a bit-serial restoring loop. While it runs, `busy` stalls further issue, and `done` marks the cycle in which the quotient is written. The divide never traps. When the divisor is zero, or when a signed divide would overflow, the result is the dividend. Any source field that names register 0 reads as zero, whatever value is on the operand port. Any result aimed at register 0 is dropped.

Top module: `int_exec_unit`

## Requirements
- R1: An accepted single-cycle operation is written in the next cycle. `wr_en` is 1 and `dest` is field B [26:22] for immediate opcodes, or field C [21:17] for opcode 58.
- R2: A result whose destination index is 0 never raises `wr_en`.
- R3: When source field A or B holds 0, that operand is taken as zero, whatever value is on `op_a` or `op_b`.
- R4: The immediate ALU opcodes work as follows. addi (4) and muli (36, low 32 bits) sign-extend imm16. andi (12), ori (20) and xori (28) zero-extend it. andhi (44), orhi (52) and xorhi (60) use imm16 shifted left by 16.
- R5: Immediate compares write 1 or 0. cmpgei (8), cmplti (16), cmpnei (24) and cmpeqi (32) use the sign-extended imm16. cmpgeui (40) and cmpltui (48) use the zero-extended imm16 in an unsigned compare.
- R6: Register compares by extended opcode are cmpge 8, cmplt 16, cmpne 24 and cmpeq 32, all signed, and cmpgeu 40 and cmpltu 48, both unsigned.
- R7: The shifts by rB[4:0] are sll 19, srl 27, sra 59, rol 3 and ror 11. The shifts by the 5-bit field are slli 18, srli 26, srai 58 and roli 2.
- R8: add 49, sub 57, and 14, or 22, xor 30, nor 6, and mul 39, which keeps the low 32 bits of the product.
- R9: The following return the upper 32 bits of the 64-bit product: mulxss 31 (both operands signed), mulxuu 7 (both unsigned) and mulxsu 23 (A signed, B unsigned).
- R10: Signed divide (extended opcode 37) truncates toward zero. It returns the dividend when the divisor is 0, or when the dividend is 0x80000000 and the divisor is 0xFFFFFFFF.
- R11: Unsigned divide (extended opcode 36) returns the dividend when the divisor is 0.
- R12: After a divide is accepted, `busy` is high for exactly 32 cycles. It then falls, and in the same cycle `done` is high for one cycle along with the quotient, `dest` set to field C, and `wr_en` set if C is nonzero.
- R13: Issue while `busy` is high is ignored, and so are undefined opcodes. Neither produces a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| insn | input | 32 | Instruction word |
| op_a | input | 32 | Value of register A |
| op_b | input | 32 | Value of register B |
| result | output | 32 | Result value |
| dest | output | 5 | Destination register index |
| wr_en | output | 1 | Write strobe for result |
| busy | output | 1 | Divider running, issue stalled |
| done | output | 1 | Divide finished this cycle |

## Verification
On every cycle, the assertions check the following: no write ever targets register 0; no write appears while the divider is busy; `done` is a single-cycle pulse that follows `busy`; an addi lands on field B one cycle later; and a divide always raises `busy`. The arithmetic values can only be shown by the bench's sweeps. These cover every operation over a grid of corner operands, with the expected results computed independently. The same applies to the divide substitutions, the exact 32-cycle busy window, and the zero-register operand rule.

// File: rtl/int_exec_unit.sv
module int_exec_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue_valid,
  input  logic [31:0] insn,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  output logic [31:0] result,
  output logic [4:0]  dest,
  output logic        wr_en,
  output logic        busy,
  output logic        done
);
  localparam logic [5:0] OP_RTYPE = 6'd58;

  wire [5:0]  op    = insn[5:0];
  wire [5:0]  opx   = insn[16:11];
  wire [4:0]  imm5  = insn[10:6];
  wire [15:0] imm16 = insn[21:6];
  wire [4:0]  fa    = insn[31:27];
  wire [4:0]  fb    = insn[26:22];
  wire [4:0]  fc    = insn[21:17];
  wire        is_r  = (op == OP_RTYPE);

  wire [31:0] a  = (fa == 5'd0) ? 32'd0 : op_a;
  wire [31:0] b  = (fb == 5'd0) ? 32'd0 : op_b;
  wire [31:0] sx = {{16{imm16[15]}}, imm16};
  wire [31:0] zx = {16'd0, imm16};
  wire [31:0] hx = {imm16, 16'd0};
  wire [4:0]  wdest = is_r ? fc : fb;

  wire        imm_sh = (opx == 6'd18) || (opx == 6'd26) || (opx == 6'd58) || (opx == 6'd2);
  wire [4:0]  sh  = imm_sh ? imm5 : b[4:0];
  wire [63:0] dbl = {a, a};
  wire [63:0] rl  = dbl << sh;
  wire [63:0] rr  = dbl >> sh;

  wire        a_sgn = (opx == 6'd31) || (opx == 6'd23);
  wire        b_sgn = (opx == 6'd31);
  wire [32:0] ea = {a_sgn & a[31], a};
  wire [32:0] eb = {b_sgn & b[31], b};
  wire [65:0] prod = {{33{ea[32]}}, ea} * {{33{eb[32]}}, eb};

  logic [31:0] res;
  logic        ok;

  always_comb begin
    ok  = 1'b1;
    res = 32'd0;
    if (is_r) begin
      case (opx)
        6'd49: res = a + b;
        6'd57: res = a - b;
        6'd14: res = a & b;
        6'd22: res = a | b;
        6'd30: res = a ^ b;
        6'd6:  res = ~(a | b);
        6'd39: res = a * b;
        6'd31, 6'd7, 6'd23: res = prod[63:32];
        6'd8:  res = {31'd0, $signed(a) >= $signed(b)};
        6'd16: res = {31'd0, $signed(a) <  $signed(b)};
        6'd24: res = {31'd0, a != b};
        6'd32: res = {31'd0, a == b};
        6'd40: res = {31'd0, a >= b};
        6'd48: res = {31'd0, a <  b};
        6'd19, 6'd18: res = a << sh;
        6'd27, 6'd26: res = a >> sh;
        6'd59, 6'd58: res = $signed(a) >>> sh;
        6'd3,  6'd2:  res = rl[63:32];
        6'd11: res = rr[31:0];
        default: ok = 1'b0;
      endcase
    end else begin
      case (op)
        6'd4:  res = a + sx;
        6'd36: res = a * sx;
        6'd12: res = a & zx;
        6'd20: res = a | zx;
        6'd28: res = a ^ zx;
        6'd44: res = a & hx;
        6'd52: res = a | hx;
        6'd60: res = a ^ hx;
        6'd8:  res = {31'd0, $signed(a) >= $signed(sx)};
        6'd16: res = {31'd0, $signed(a) <  $signed(sx)};
        6'd24: res = {31'd0, a != sx};
        6'd32: res = {31'd0, a == sx};
        6'd40: res = {31'd0, a >= zx};
        6'd48: res = {31'd0, a <  zx};
        default: ok = 1'b0;
      endcase
    end
  end

  wire        is_div = is_r && ((opx == 6'd36) || (opx == 6'd37));
  wire        dsgn   = (opx == 6'd37);
  wire        subst  = (b == 32'd0) ||
                       (dsgn && (a == 32'h8000_0000) && (b == 32'hFFFF_FFFF));
  wire [31:0] dv     = subst ? 32'd1 : b;
  wire [31:0] mag_a  = (dsgn && a[31])  ? -a  : a;
  wire [31:0] mag_b  = (dsgn && dv[31]) ? -dv : dv;

  logic [31:0] rem, quo, dvs, dreg_unused;
  logic [4:0]  dreg;
  logic        neg_q;
  logic [5:0]  cnt;

  wire [32:0] trial = {rem, quo[31]} - {1'b0, dvs};
  wire        take  = ~trial[32];
  wire [31:0] nrem  = take ? trial[31:0] : {rem[30:0], quo[31]};
  wire [31:0] nquo  = {quo[30:0], take};

  assign dreg_unused = 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= 32'd0;
      dest   <= 5'd0;
      wr_en  <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      rem    <= 32'd0;
      quo    <= 32'd0;
      dvs    <= 32'd0;
      neg_q  <= 1'b0;
      dreg   <= 5'd0;
      cnt    <= 6'd0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      if (busy) begin
        rem <= nrem;
        quo <= nquo;
        if (cnt == 6'd1) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= neg_q ? -nquo : nquo;
          dest   <= dreg;
          wr_en  <= (dreg != 5'd0);
        end else begin
          cnt <= cnt - 6'd1;
        end
      end else if (issue_valid) begin
        if (is_div) begin
          busy  <= 1'b1;
          cnt   <= 6'd32;
          rem   <= 32'd0;
          quo   <= mag_a;
          dvs   <= mag_b;
          neg_q <= dsgn && (a[31] ^ dv[31]);
          dreg  <= fc;
        end else if (ok) begin
          result <= res;
          dest   <= wdest;
          wr_en  <= (wdest != 5'd0);
        end
      end
    end
  end
endmodule

module int_exec_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_valid,
  input logic [31:0] insn,
  input logic [4:0]  dest,
  input logic        wr_en,
  input logic        busy,
  input logic        done
);
  assert_no_zero_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> dest != 5'd0);
  assert_addi_lands_on_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !busy && insn[5:0] == 6'd4 && insn[26:22] != 5'd0)
      |=> (wr_en && dest == $past(insn[26:22])));
  assert_no_write_while_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_en);
  assert_div_raises_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !busy && insn[5:0] == 6'd58 &&
     (insn[16:11] == 6'd36 || insn[16:11] == 6'd37)) |=> busy);
  assert_done_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));
endmodule

bind int_exec_unit int_exec_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .insn(insn),
  .dest(dest), .wr_en(wr_en), .busy(busy), .done(done)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [31:0] insn = 32'd0, op_a = 32'd0, op_b = 32'd0;
  logic [31:0] result;
  logic [4:0]  dest;
  logic        wr_en, busy, done;
  int checks = 0;
  int failures = 0;

  int_exec_unit u_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .insn(insn),
    .op_a(op_a), .op_b(op_b), .result(result), .dest(dest),
    .wr_en(wr_en), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_i(input int op, input logic [4:0] ra, input logic [4:0] rb,
                                       input logic [15:0] imm);
    return {ra, rb, imm, 6'(op)};
  endfunction

  function automatic logic [31:0] mk_r(input int x, input logic [4:0] ra, input logic [4:0] rb,
                                       input logic [4:0] rc, input logic [4:0] i5);
    return {ra, rb, rc, 6'(x), i5, 6'd58};
  endfunction

  function automatic logic [31:0] rotl(input logic [31:0] v, input logic [4:0] s);
    return (v << s) | (v >> (6'd32 - {1'b0, s}));
  endfunction

  function automatic logic [31:0] ref_r(input int x, input logic [31:0] a, input logic [31:0] b,
                                        input logic [4:0] i5);
    longint p;
    logic [63:0] u;
    logic [4:0] s;
    s = b[4:0];
    case (x)
      49: return a + b;
      57: return a - b;
      14: return a & b;
      22: return a | b;
      30: return a ^ b;
      6:  return ~(a | b);
      39: return a * b;
      31: begin p = longint'($signed(a)) * longint'($signed(b)); return p[63:32]; end
      7:  begin u = {32'd0, a} * {32'd0, b}; return u[63:32]; end
      23: begin p = longint'($signed(a)) * longint'({32'd0, b}); return p[63:32]; end
      8:  return {31'd0, $signed(a) >= $signed(b)};
      16: return {31'd0, $signed(a) <  $signed(b)};
      24: return {31'd0, a != b};
      32: return {31'd0, a == b};
      40: return {31'd0, a >= b};
      48: return {31'd0, a <  b};
      19: return a << s;
      27: return a >> s;
      59: return $signed(a) >>> s;
      3:  return rotl(a, s);
      11: return rotl(a, 5'(6'd32 - {1'b0, s}));
      18: return a << i5;
      26: return a >> i5;
      58: return $signed(a) >>> i5;
      2:  return rotl(a, i5);
      37: begin
            if (b == 0 || (a == 32'h8000_0000 && b == 32'hFFFF_FFFF)) return a;
            return $signed(a) / $signed(b);
          end
      36: return (b == 0) ? a : a / b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] ref_i(input int op, input logic [31:0] a, input logic [15:0] imm);
    logic [31:0] sx, zx, hx;
    sx = {{16{imm[15]}}, imm};
    zx = {16'd0, imm};
    hx = {imm, 16'd0};
    case (op)
      4:  return a + sx;
      36: return a * sx;
      12: return a & zx;
      20: return a | zx;
      28: return a ^ zx;
      44: return a & hx;
      52: return a | hx;
      60: return a ^ hx;
      8:  return {31'd0, $signed(a) >= $signed(sx)};
      16: return {31'd0, $signed(a) <  $signed(sx)};
      24: return {31'd0, a != sx};
      32: return {31'd0, a == sx};
      40: return {31'd0, a >= zx};
      48: return {31'd0, a <  zx};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_r(input int x);
    case (x)
      49, 57, 14, 22, 30, 6, 39: return "R8";
      31, 7, 23: return "R9";
      8, 16, 24, 32, 40, 48: return "R6";
      37: return "R10";
      36: return "R11";
      default: return "R7";
    endcase
  endfunction

  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    issue_valid = 1'b1; insn = ins; op_a = a; op_b = b;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic run_single(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] exp, input logic [4:0] exp_dest, input string req);
    issue(ins, a, b);
    check({req, " R1 wr_en"}, {31'd0, wr_en}, 32'd1);
    check({req, " R1 dest"}, {27'd0, dest}, {27'd0, exp_dest});
    check(req, result, exp);
  endtask

  task automatic run_div(input int x, input logic [31:0] a, input logic [31:0] b);
    int bcnt = 0;
    int guard = 0;
    issue(mk_r(x, 5'd1, 5'd2, 5'd3, 5'd0), a, b);
    while (!done && guard < 100) begin
      if (busy) bcnt++;
      guard++;
      @(negedge clk);
    end
    check("R12 busy cycles", bcnt, 32);
    check("R12 busy low at done", {31'd0, busy}, 32'd0);
    check("R12 wr_en with done", {31'd0, wr_en}, 32'd1);
    check("R12 dest", {27'd0, dest}, 32'd3);
    check(tag_r(x), result, ref_r(x, a, b, 5'd0));
  endtask

  logic [31:0] vals [12] = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'd2, 32'h7FFF_FFFF, 32'h8000_0000,
                             32'h1234_5678, 32'hFFFF_FFF0, 32'd5, 32'hFFFF_FFF9, 32'd31, 32'd33};
  logic [15:0] imms [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h1234, 16'h0005, 16'hFFF0};
  int rops [21] = '{49, 57, 14, 22, 30, 6, 39, 31, 7, 23, 8, 16, 24, 32, 40, 48, 19, 27, 59, 3, 11};
  int iops [14] = '{4, 36, 12, 20, 28, 44, 52, 60, 8, 16, 24, 32, 40, 48};
  int shops [4] = '{18, 26, 58, 2};
  logic [4:0] shamts [4] = '{5'd0, 5'd1, 5'd4, 5'd31};

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL R12 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset wr_en", {31'd0, wr_en}, 32'd0);
    check("R12 reset busy", {31'd0, busy}, 32'd0);
    check("R12 reset done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;

    foreach (rops[k])
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          run_single(mk_r(rops[k], 5'd1, 5'd2, 5'd3, 5'd0), vals[i], vals[j],
                     ref_r(rops[k], vals[i], vals[j], 5'd0), 5'd3, tag_r(rops[k]));

    foreach (shops[k])
      for (int i = 0; i < 12; i++)
        for (int s = 0; s < 4; s++)
          run_single(mk_r(shops[k], 5'd1, 5'd2, 5'd4, shamts[s]), vals[i], 32'hFFFF_FFFF,
                     ref_r(shops[k], vals[i], 32'hFFFF_FFFF, shamts[s]), 5'd4, "R7");

    foreach (iops[k])
      for (int i = 0; i < 12; i++)
        for (int m = 0; m < 8; m++)
          run_single(mk_i(iops[k], 5'd1, 5'd7, imms[m]), vals[i], 32'hDEAD_BEEF,
                     ref_i(iops[k], vals[i], imms[m]), 5'd7,
                     (iops[k] == 8 || iops[k] == 16 || iops[k] == 24 || iops[k] == 32 ||
                      iops[k] == 40 || iops[k] == 48) ? "R5" : "R4");

    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++) begin
        run_div(37, vals[i], vals[j]);
        run_div(36, vals[i], vals[j]);
      end

    // R2: destination 0 is never written
    issue(mk_i(4, 5'd1, 5'd0, 16'd9), 32'd1, 32'd0);
    check("R2 imm dest zero", {31'd0, wr_en}, 32'd0);
    issue(mk_r(49, 5'd1, 5'd2, 5'd0, 5'd0), 32'd1, 32'd2);
    check("R2 reg dest zero", {31'd0, wr_en}, 32'd0);

    // R3: field value 0 forces the operand to zero
    run_single(mk_r(49, 5'd0, 5'd2, 5'd5, 5'd0), 32'h5555_0000, 32'd7, 32'd7, 5'd5, "R3 A zero");
    run_single(mk_r(57, 5'd1, 5'd0, 5'd5, 5'd0), 32'd40, 32'h0BAD_0BAD, 32'd40, 5'd5, "R3 B zero");
    run_single(mk_i(20, 5'd0, 5'd6, 16'h00F0), 32'hFFFF_FFFF, 32'd0, 32'h0000_00F0, 5'd6, "R3 imm A zero");

    // R13: undefined opcodes produce no write
    issue(mk_i(2, 5'd1, 5'd2, 16'd1), 32'd1, 32'd1);
    check("R13 undefined opcode", {31'd0, wr_en}, 32'd0);
    issue(mk_r(0, 5'd1, 5'd2, 5'd3, 5'd0), 32'd1, 32'd1);
    check("R13 undefined ext opcode", {31'd0, wr_en}, 32'd0);

    // R13: issue during busy is ignored
    issue(mk_r(36, 5'd1, 5'd2, 5'd9, 5'd0), 32'd100, 32'd7);
    begin
      int spurious = 0;
      int guard = 0;
      issue_valid = 1'b1; insn = mk_i(4, 5'd1, 5'd10, 16'd1); op_a = 32'd5; op_b = 32'd0;
      while (!done && guard < 100) begin
        if (wr_en) spurious++;
        guard++;
        @(negedge clk);
      end
      check("R13 no write while busy", spurious, 0);
      check("R13 divide result kept", result, 32'd14);
      check("R13 divide dest kept", {27'd0, dest}, 32'd9);
      issue_valid = 1'b0;
      @(negedge clk);
      check("R13 stalled issue not replayed", {31'd0, wr_en}, 32'd0);
    end

    // R12: divide aimed at register 0 finishes without a write
    issue(mk_r(37, 5'd1, 5'd2, 5'd0, 5'd0), 32'd9, 32'd3);
    begin
      int guard = 0;
      while (!done && guard < 100) begin guard++; @(negedge clk); end
      check("R12 done for dest zero", {31'd0, done}, 32'd1);
      check("R2 divide dest zero", {31'd0, wr_en}, 32'd0);
    end
    @(negedge clk);
    check("R12 done one cycle", {31'd0, done}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule